// File: doc/BRIEF.md
# Held-Key Autorepeat Marker Generator

This block sits beside a key-event queue and tells the host that a key is still being held. It watches a level that is high while at least one key is down, a strobe for every press or release event that is being recorded, and a tick that marks the end of each debounce cycle. Once keys have been held, with no new event, for a programmed initial delay, it offers one repeat marker (code 0x7E) to the queue. It then offers another marker after every programmed repeat period until a new key event arrives. The marker carries no key identity, so only one marker is produced per interval however many keys are down.

The block reads an 8-bit settings byte with three fields. Bit 7 is the enable. Bits 3:0 hold the delay code, giving a delay of (code+1)×8 debounce cycles. Bits 6:4 hold the period code, giving a period of (code+1)×4 debounce cycles. The marker leaves on a valid/ready stream. Once valid is raised it stays high, with the marker code on the data lines, until the cycle in which ready is high. A marker that is not yet accepted absorbs any further interval expiries, so back-pressure never stacks up more than one marker. The control inputs are plain levels and strobes with no handshake.

Top module: `ar_repeat_gen`

## Requirements
- R1: With settings bit 7 at 0 (the settings reset value is 0x00), no marker is ever offered, whatever the other inputs do.
- R2: The initial delay is (bits 3:0 + 1) × 8 counted ticks after the last key event, from 8 to 128 ticks; the first marker comes from the tick that completes it.
- R3: After the first marker, further markers follow every (bits 6:4 + 1) × 4 counted ticks, from 4 to 32 ticks, while keys stay held and no event arrives.
- R4: Whenever marker_valid_o is high, marker_code_o equals 0x7E.
- R5: At most one marker is outstanding at a time: interval expiries while a marker awaits acceptance produce no extra marker.
- R6: A key event while keys are held restarts the full initial delay from zero, including a release event after which keys remain down.
- R7: While no key is held the interval count is idle and no new marker is created; holding keys again starts a fresh initial delay.
- R8: Once marker_valid_o is high it stays high until a cycle with marker_ready_i high, and it drops after that cycle unless a new marker is created in the same cycle.
- R9: A tick in the same cycle as a key event, or in the first cycle that keys are held and the block is enabled, is not counted.
- R10: If the settings shrink an interval below the ticks already counted, the next counted tick completes that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| debounce_tick_i | input | 1 | One-cycle pulse at the end of each debounce cycle |
| any_key_held_i | input | 1 | High while at least one key is held down |
| key_event_i | input | 1 | One-cycle strobe for each recorded press or release |
| repeat_cfg_i | input | 8 | Settings: bit 7 enable, bits 6:4 period code, bits 3:0 delay code |
| marker_ready_i | input | 1 | Queue accepts the offered marker this cycle |
| marker_valid_o | output | 1 | A repeat marker is offered |
| marker_code_o | output | 8 | Marker code, 0x7E |

## Verification
A marker is created in the clock cycle whose tick completes an interval, and marker_valid_o is high from the next clock edge onward. A handshake takes effect at the edge where valid and ready are both high. The bench holds its inputs still across each rising edge and updates a behavioural model at that edge. At every falling edge it compares valid and code with the model, so each result is checked exactly one register stage after the stimulus. The accepted-marker totals for each scenario are worked out by hand from the delay and period lengths, and they are read only after a settling gap of several cycles, so that the last marker created has been accepted.

// File: rtl/ar_repeat_pkg.sv
package ar_repeat_pkg;

  // Interval timer phase.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DELAY  = 2'd1,
    PH_REPEAT = 2'd2
  } ar_phase_e;

  // Settings byte layout: enable on top, period code, then delay code.
  typedef struct packed {
    logic       enable;
    logic [2:0] period_code;
    logic [3:0] delay_code;
  } ar_cfg_t;

  localparam logic [7:0] AR_MARKER_CODE = 8'h7E;

endpackage

// File: rtl/ar_cfg_decode.sv
module ar_cfg_decode
  import ar_repeat_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DELAY_UNIT  = 8,
  parameter int PERIOD_UNIT = 4
) (
  input  logic [7:0]       cfg_i,
  output logic             enable_o,
  output logic [CNT_W-1:0] delay_len_o,
  output logic [CNT_W-1:0] period_len_o
);

  ar_cfg_t fields;

  always_comb begin
    fields       = ar_cfg_t'(cfg_i);
    enable_o     = fields.enable;
    delay_len_o  = (CNT_W'(fields.delay_code) + CNT_W'(1)) * CNT_W'(DELAY_UNIT);
    period_len_o = (CNT_W'(fields.period_code) + CNT_W'(1)) * CNT_W'(PERIOD_UNIT);
  end

endmodule

// File: rtl/ar_interval_timer.sv
module ar_interval_timer
  import ar_repeat_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] delay_len_i,
  input  logic [CNT_W-1:0] period_len_i,
  output logic             fire_o
);

  ar_phase_e        phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_inc;
  logic             done;

  always_comb begin
    limit   = (phase_q == PH_DELAY) ? delay_len_i : period_len_i;
    cnt_inc = cnt_q + CNT_W'(1);
    done    = (cnt_inc >= limit);
    fire_o  = run_i && (phase_q != PH_IDLE) && !evt_i && tick_i && done;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (!run_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (phase_q == PH_IDLE || evt_i) begin
      phase_q <= PH_DELAY;
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (done) begin
        phase_q <= PH_REPEAT;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end

  AST_EVT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && evt_i) |=> (phase_q == PH_DELAY && cnt_q == '0)); // R6

  AST_IDLE_NO_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (phase_q == PH_IDLE && cnt_q == '0)); // R7

  AST_FIRE_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (tick_i && !evt_i && $past(run_i))); // R9

endmodule

// File: rtl/ar_marker_slot.sv
module ar_marker_slot #(
  parameter int         DATA_W = 8,
  parameter logic [7:0] CODE   = 8'h7E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  logic valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= (valid_q && !ready_i) || fire_i;
  end

  assign valid_o = valid_q;
  assign data_o  = DATA_W'(CODE);

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> valid_q); // R8

  AST_FIRE_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> valid_q); // R5

  AST_ACCEPT_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && ready_i && !fire_i) |=> !valid_q); // R8

endmodule

// File: rtl/ar_repeat_gen.sv
module ar_repeat_gen
  import ar_repeat_pkg::*;
#(
  parameter int DELAY_UNIT  = 8,
  parameter int PERIOD_UNIT = 4,
  parameter int DELAY_BITS  = 4,
  parameter int DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              debounce_tick_i,
  input  logic              any_key_held_i,
  input  logic              key_event_i,
  input  logic [7:0]        repeat_cfg_i,
  input  logic              marker_ready_i,
  output logic              marker_valid_o,
  output logic [DATA_W-1:0] marker_code_o
);

  localparam int MAX_LEN = DELAY_UNIT * (2 ** DELAY_BITS);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic             enable;
  logic [CNT_W-1:0] delay_len;
  logic [CNT_W-1:0] period_len;
  logic             fire;
  logic             run;

  ar_cfg_decode #(
    .CNT_W      (CNT_W),
    .DELAY_UNIT (DELAY_UNIT),
    .PERIOD_UNIT(PERIOD_UNIT)
  ) u_decode (
    .cfg_i       (repeat_cfg_i),
    .enable_o    (enable),
    .delay_len_o (delay_len),
    .period_len_o(period_len)
  );

  assign run = enable && any_key_held_i;

  ar_interval_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .tick_i      (debounce_tick_i),
    .evt_i       (key_event_i),
    .delay_len_i (delay_len),
    .period_len_i(period_len),
    .fire_o      (fire)
  );

  ar_marker_slot #(
    .DATA_W(DATA_W),
    .CODE  (AR_MARKER_CODE)
  ) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .ready_i(marker_ready_i),
    .valid_o(marker_valid_o),
    .data_o (marker_code_o)
  );

  AST_OFF_NO_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(marker_valid_o) |-> $past(repeat_cfg_i[7] && any_key_held_i)); // R1

endmodule

// File: tb/ar_repeat_gen_tb_top.sv
module ar_repeat_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       held = 1'b0;
  logic       evt = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       ready = 1'b1;
  logic       vld;
  logic [7:0] code;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int hs_cnt = 0;
  string cur_req = "R1";

  // behavioural model state
  int  m_phase = 0;
  int  m_ticks = 0;
  bit  m_pend = 0;

  always #2 clk = ~clk;

  ar_repeat_gen dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .debounce_tick_i(tick),
    .any_key_held_i (held),
    .key_event_i    (evt),
    .repeat_cfg_i   (cfg),
    .marker_ready_i (ready),
    .marker_valid_o (vld),
    .marker_code_o  (code)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_ticks = 0; m_pend = 0;
    end else begin
      bit fire;
      int lim;
      fire = 0;
      if (vld && ready) hs_cnt++;
      if (!(cfg[7] && held)) begin
        m_phase = 0; m_ticks = 0;
      end else if (m_phase == 0 || evt) begin
        m_phase = 1; m_ticks = 0;
      end else if (tick) begin
        lim = (m_phase == 1) ? (int'(cfg[3:0]) + 1) * 8 : (int'(cfg[6:4]) + 1) * 4;
        if (m_ticks + 1 >= lim) begin
          fire = 1; m_phase = 2; m_ticks = 0;
        end else m_ticks++;
      end
      m_pend = (m_pend && !ready) || fire;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      checks++;
      if (vld !== m_pend) begin
        errors++;
        $display("FAIL %s cycle %0d: marker_valid_o=%0b expected %0b", cur_req, cyc, vld, m_pend);
      end
      if (vld) begin
        checks++;
        if (code !== 8'h7E) begin
          errors++;
          $display("FAIL R4 cycle %0d: marker_code_o=%h expected 7e", cyc, code);
        end
      end
    end
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected fewer", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input bit t, input bit h, input bit e);
    @(negedge clk); #1;
    tick = t; held = h; evt = e;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0);
  endtask

  task automatic settle();
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0);
    ready = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic expect_hs(input string req, input int exp);
    @(negedge clk); #1;
    checks++;
    if (hs_cnt != exp) begin
      errors++;
      $display("FAIL %s: accepted markers=%0d expected %0d", req, hs_cnt, exp);
    end
    hs_cnt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    checks++;
    if (vld !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: marker_valid_o=%0b expected 0", vld);
    end
    hs_cnt = 0;

    // R1: disabled, default and non-default other fields
    cur_req = "R1";
    cfg = 8'h00; step(1, 1, 1); run_ticks(300); settle(); expect_hs("R1", 0);
    cfg = 8'h7F; step(1, 1, 1); run_ticks(300); settle(); expect_hs("R1", 0);

    // R2/R3: delay 8, period 4, 30 counted ticks -> 8,12,..,28
    cur_req = "R2";
    cfg = 8'h80; step(1, 1, 1); run_ticks(30); settle(); expect_hs("R2", 6);
    // delay 32, period 12, 80 ticks -> 32,44,56,68,80
    cur_req = "R3";
    cfg = 8'hA3; step(1, 1, 1); run_ticks(80); settle(); expect_hs("R3", 5);
    // maximum codes: delay 128, period 32, 200 ticks -> 128,160,192
    cfg = 8'hFF; step(1, 1, 1); run_ticks(200); settle(); expect_hs("R3", 3);

    // R6: new event with keys still down restarts delay
    cur_req = "R6";
    cfg = 8'h80; step(1, 1, 1); run_ticks(6); step(1, 1, 1); run_ticks(7);
    expect_hs("R6", 0);
    run_ticks(1); step(0, 1, 0); step(0, 1, 0); expect_hs("R6", 1);
    settle(); hs_cnt = 0;

    // R7: no key held
    cur_req = "R7";
    for (int i = 0; i < 100; i++) step(1, 0, (i % 10) == 0);
    settle(); expect_hs("R7", 0);

    // R9: entry without event, first cycle tick not counted
    cur_req = "R9";
    step(1, 1, 0); run_ticks(7); step(0, 1, 0); step(0, 1, 0); expect_hs("R9", 0);
    run_ticks(1); step(0, 1, 0); step(0, 1, 0); expect_hs("R9", 1);
    settle(); hs_cnt = 0;

    // R5/R8: back-pressure merges expiries into one marker
    cur_req = "R8";
    ready = 1'b0;
    step(1, 1, 1); run_ticks(30);
    @(negedge clk); #1;
    checks++;
    if (vld !== 1'b1) begin
      errors++;
      $display("FAIL R8: marker_valid_o=%0b expected 1 under back-pressure", vld);
    end
    cur_req = "R5";
    settle(); expect_hs("R5", 1);

    // R10: shrink delay below the count already reached
    cur_req = "R10";
    cfg = 8'h8F; step(1, 1, 1); run_ticks(50);
    step(0, 1, 0); cfg = 8'h80; step(0, 1, 0); expect_hs("R10", 0);
    run_ticks(1); step(0, 1, 0); step(0, 1, 0); expect_hs("R10", 1);
    settle(); hs_cnt = 0;

    // sparse ticks and intermittent ready, model compared every cycle
    cur_req = "R3";
    cfg = 8'h91; step(0, 1, 1);
    for (int i = 0; i < 240; i++) begin
      ready = (i % 5) != 2;
      step((i % 3) == 0, 1, (i == 120));
    end
    settle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule